// File: doc/BRIEF.md
# Stop-and-Wait Link Receiver Controller

This block sits on the receiving side of a stop-and-wait retransmission link. Another block frames each incoming packet and checks its CRC. When a frame is complete, that block pulses a strobe and presents two things: a flag that says whether the check passed, and the sequence number taken from the frame header. One cycle later the controller decides three things: whether the payload goes downstream, whether the sender gets a positive or a negative acknowledgement, and which sequence value that response carries.

The controller keeps one register, the sequence number it expects next. It uses the header number alone to tell a new packet from a repeat, and never looks at payload contents. A repeat arrives when the sender timed out or an earlier acknowledgement was lost. The repeat is acknowledged again but is not handed downstream a second time, so each packet leaves the receiver exactly once. Every response carries the receiver's current expected number, which lets the sender see whether its outstanding packet has been taken. The sequence width is a parameter; one bit gives the classic alternating-bit scheme.

Top module: `sw_arq_rx`

## Requirements
- R1: While `rst_n` is low, `deliver`, `rsp_valid` and `rsp_is_ack` are 0 and `rsp_seq` is 0. The first error-free frame after reset with header number 0 is delivered.
- R2: Every output change is registered. When `frm_valid` is low at a clock edge, `deliver` and `rsp_valid` are 0 in the following cycle. Values on `frm_crc_ok` and `frm_seq` have no effect while `frm_valid` is low.
- R3: A frame with `frm_crc_ok` = 0 produces, one cycle later, `rsp_valid` = 1 and `rsp_is_ack` = 0 (a nak) with `deliver` = 0. The expected number does not change.
- R4: An error-free frame whose `frm_seq` equals the expected number produces, one cycle later, `deliver` = 1, `rsp_valid` = 1 and `rsp_is_ack` = 1. `rsp_seq` then shows the expected number plus one.
- R5: An error-free frame whose `frm_seq` differs from the expected number (a repeat) produces, one cycle later, an ack with `deliver` = 0. `rsp_seq` is unchanged.
- R6: The expected number, shown on `rsp_seq`, advances by one only on a delivery and wraps modulo 2^SEQ_W. It is stable in every other cycle.
- R7: Frames on consecutive cycles each get exactly one response, in the cycle after their strobe.
- R8: While `rsp_valid` is 0, `rsp_is_ack` keeps the kind of the last response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| frm_valid | input | 1 | One-cycle strobe: a frame has been completely received |
| frm_crc_ok | input | 1 | 1 when the frame passed its CRC check |
| frm_seq | input | SEQ_W | Sequence number from the frame header |
| deliver | output | 1 | One-cycle strobe: release the buffered payload downstream |
| rsp_valid | output | 1 | One-cycle strobe: send a response to the sender |
| rsp_is_ack | output | 1 | Response kind: 1 = ack, 0 = nak |
| rsp_seq | output | SEQ_W | Expected sequence number, carried in the response |

## Verification
The bench builds the controller with SEQ_W = 2 rather than the one-bit default. With a two-bit number, the expected value wraps from 3 back to 0 within a short script. It also allows a stale header number that is neither the current nor the previous packet. Both cases exercise the modulo comparison that a single bit would hide. The scripted streams include lost frames, corrupted frames and repeated copies of the same packet, so the order of deliveries and the numbers carried by acks can be checked against a hand-worked trace.

// File: rtl/sw_arq_rx.sv
module sw_arq_rx #(
  parameter int SEQ_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm_valid,
  input  logic             frm_crc_ok,
  input  logic [SEQ_W-1:0] frm_seq,
  output logic             deliver,
  output logic             rsp_valid,
  output logic             rsp_is_ack,
  output logic [SEQ_W-1:0] rsp_seq
);

  logic [SEQ_W-1:0] exp_q;
  logic             is_new;

  assign is_new  = frm_valid && frm_crc_ok && (frm_seq == exp_q);
  assign rsp_seq = exp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exp_q      <= '0;
      deliver    <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_is_ack <= 1'b0;
    end else begin
      deliver   <= is_new;
      rsp_valid <= frm_valid;
      if (frm_valid)
        rsp_is_ack <= frm_crc_ok;
      if (is_new)
        exp_q <= exp_q + SEQ_W'(1);
    end
  end

endmodule

// File: rtl/sw_arq_rx_chk.sv
module sw_arq_rx_chk #(
  parameter int SEQ_W = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frm_valid,
  input logic             frm_crc_ok,
  input logic [SEQ_W-1:0] frm_seq,
  input logic             deliver,
  input logic             rsp_valid,
  input logic             rsp_is_ack,
  input logic [SEQ_W-1:0] rsp_seq
);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid |=> (!rsp_valid && !deliver));

  assert_one_rsp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> rsp_valid);

  assert_nak_no_dlv_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !frm_crc_ok) |=> (!deliver && !rsp_is_ack && $stable(rsp_seq)));

  assert_good_acked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_crc_ok) |=> rsp_is_ack);

  assert_dlv_seq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_crc_ok && frm_seq != rsp_seq) |=> !deliver);

  assert_dlv_adv_R6: assert property (@(posedge clk) disable iff (!rst_n)
    deliver |-> (rsp_seq == SEQ_W'($past(frm_seq) + 1)));

  assert_seq_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !deliver |-> $stable(rsp_seq));

  assert_kind_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> $stable(rsp_is_ack));

endmodule

bind sw_arq_rx sw_arq_rx_chk #(.SEQ_W(SEQ_W)) u_chk (.*);

// File: tb/sw_arq_rx_bench.sv
module sw_arq_rx_bench;
  localparam int SW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frm_valid = 1'b0;
  logic frm_crc_ok = 1'b0;
  logic [SW-1:0] frm_seq = '0;
  logic deliver, rsp_valid, rsp_is_ack;
  logic [SW-1:0] rsp_seq;

  int checks = 0;
  int fails = 0;
  int dlv_count = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sw_arq_rx #(.SEQ_W(SW)) u_sw_arq_rx (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_crc_ok(frm_crc_ok),
    .frm_seq(frm_seq), .deliver(deliver), .rsp_valid(rsp_valid),
    .rsp_is_ack(rsp_is_ack), .rsp_seq(rsp_seq)
  );

  always @(negedge clk) if (rst_n && deliver) dlv_count++;

  // vector: {crc_ok, seq[1:0], exp_deliver, exp_ack, exp_rsp_seq[1:0]}
  localparam logic [6:0] VEC [14] = '{
    {1'b1, 2'd0, 1'b1, 1'b1, 2'd1},
    {1'b1, 2'd0, 1'b0, 1'b1, 2'd1},
    {1'b0, 2'd1, 1'b0, 1'b0, 2'd1},
    {1'b1, 2'd1, 1'b1, 1'b1, 2'd2},
    {1'b1, 2'd1, 1'b0, 1'b1, 2'd2},
    {1'b1, 2'd1, 1'b0, 1'b1, 2'd2},
    {1'b1, 2'd2, 1'b1, 1'b1, 2'd3},
    {1'b0, 2'd3, 1'b0, 1'b0, 2'd3},
    {1'b0, 2'd0, 1'b0, 1'b0, 2'd3},
    {1'b1, 2'd3, 1'b1, 1'b1, 2'd0},
    {1'b1, 2'd3, 1'b0, 1'b1, 2'd0},
    {1'b1, 2'd0, 1'b1, 1'b1, 2'd1},
    {1'b1, 2'd2, 1'b0, 1'b1, 2'd1},
    {1'b1, 2'd1, 1'b1, 1'b1, 2'd2}
  };

  task automatic chk(input string req, input logic [4:0] got, input logic [4:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got {dlv,rv,ack,seq}=%b expected %b", req, got, exp);
    end
  endtask

  function automatic logic [4:0] obs();
    return {deliver, rsp_valid, rsp_is_ack, rsp_seq};
  endfunction

  task automatic send(input logic ok, input logic [SW-1:0] s);
    @(negedge clk);
    frm_valid = 1'b1; frm_crc_ok = ok; frm_seq = s;
    @(negedge clk);
    frm_valid = 1'b0; frm_crc_ok = 1'b0; frm_seq = '0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset state", obs(), 5'b00000);
    rst_n = 1'b1;

    for (int i = 0; i < 14; i++) begin
      send(VEC[i][6], VEC[i][5:4]);
      // R6: vectors 9 and 10 cover the wrap from 3 to 0
      if (!VEC[i][6])      chk("R3 nak", obs(), {VEC[i][3], 1'b1, VEC[i][2], VEC[i][1:0]});
      else if (VEC[i][3])  chk("R4 deliver", obs(), {VEC[i][3], 1'b1, VEC[i][2], VEC[i][1:0]});
      else                 chk("R5 repeat", obs(), {VEC[i][3], 1'b1, VEC[i][2], VEC[i][1:0]});
    end

    @(negedge clk);
    chk("R2 R8 idle after ack", obs(), 5'b00110);

    frm_crc_ok = 1'b1; frm_seq = 2'd2;
    repeat (3) @(negedge clk);
    chk("R2 inputs ignored without strobe", obs(), 5'b00110);
    frm_crc_ok = 1'b0; frm_seq = '0;
    send(1'b1, 2'd2);
    chk("R2 R6 expected unchanged by ignored inputs", obs(), 5'b11111);

    @(negedge clk);
    frm_valid = 1'b1; frm_crc_ok = 1'b1; frm_seq = 2'd3;
    @(negedge clk);
    chk("R7 first back-to-back", obs(), 5'b11100);
    frm_seq = 2'd0;
    @(negedge clk);
    frm_valid = 1'b0; frm_crc_ok = 1'b0;
    chk("R7 second back-to-back", obs(), 5'b11101);

    send(1'b0, 2'd1);
    chk("R3 nak after wrap", obs(), 5'b01001);
    @(negedge clk);
    chk("R8 nak kind held", obs(), 5'b00001);

    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 mid-run reset", obs(), 5'b00000);
    rst_n = 1'b1;
    send(1'b1, 2'd0);
    chk("R1 first frame after reset", obs(), 5'b11101);

    @(negedge clk);
    checks++;
    if (dlv_count != 10) begin
      fails++;
      $display("FAIL R4 delivery count: got %0d expected %0d", dlv_count, 10);
    end

    done = 1'b1;
    finish_run();
  end
endmodule